// File: doc/BRIEF.md
# Bus Security Attribute Filter

This block sits in the interconnect between the bus masters (a CPU and several DMA-capable peripherals) and a set of slave regions. Each request carries a master number and a normal-world flag. The filter works out the world of each request: the CPU's flag is taken as given, and every other master uses a per-master attribute bit. It then compares that world with the security attribute of the addressed slave. Permitted requests go to exactly one slave. Refused requests never reach a slave and come back with an error response in the cycle where the data would have come back.

A small configuration space holds four things: the slave attributes, the master attributes, a secure RAM window inside slave region 0 (inclusive base and limit) and a lock bit. Boot code programs these from the secure world and then sets the lock. From then until reset the attributes are frozen. The first refused request is recorded (address, master, direction) and a one-cycle violation pulse is raised for every refusal.

Top module: `sec_bus_filter`

## Requirements
- R1: A permitted request asserts exactly one `slv_sel` bit in its request cycle. The slave index is address bits [AW-2 -: log2(NSLV)] and address bit AW-1 is 0. One cycle later `rsp_valid` is 1, `rsp_err` is 0 and, for a read, `rsp_rdata` carries the selected slave's `slv_rdata` word.
- R2: A normal-world request to a secure target asserts no `slv_sel` bit. One cycle later it returns `rsp_err`=1 with `rsp_rdata`=0.
- R3: A secure-world request may access both secure and normal slaves.
- R4: The request's world is `req_ns` when `req_mid` equals CPU_ID (0). For any other master it is normal when bit `req_mid` of the master-attribute register is 0, and secure when that bit is 1.
- R5: When the window enable bit (control bit 1) is set, a slave-0 address within [base, limit], both ends included, counts as secure whatever slave 0's own attribute is.
- R6: Writing 1 to control bit 0 sets the lock, and only reset clears it. While it is set, writes to registers 0 to 4 change nothing and still complete without error.
- R7: The configuration space (address bit AW-1 = 1, register index = address bits [4:2]) is always secure. Its registers are: 0 slave attributes (bit i=1: slave i secure), 1 master attributes, 2 window base, 3 window limit, 4 control, 5 violation valid (write 1 to clear), 6 captured address, 7 captured {write, master}.
- R8: Every refused request gives a one-cycle `viol_pulse`, in the same cycle as its error response. Only the first refusal after a clear is captured in registers 5 to 7.
- R9: After reset all slaves are secure, all masters are normal, the window is off and the lock is clear.
- R10: A refused write leaves the slave's contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Write data |
| req_ns | input | 1 | CPU world flag, 1 = normal |
| req_mid | input | log2(NMST) | Master number |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Request was refused |
| rsp_rdata | output | DW | Read data, zero on error or write |
| slv_sel | output | NSLV | One-hot slave select |
| slv_write | output | 1 | Write strobe to slaves |
| slv_addr | output | AW | Address to slaves |
| slv_wdata | output | DW | Write data to slaves |
| slv_rdata | input | NSLV*DW | Per-slave read data, valid one cycle after select |
| viol_pulse | output | 1 | One-cycle pulse per refused request |

## Verification
The assertions assume three things about the environment. There is at most one request per cycle, each slave returns its read word in the cycle after it is selected, and NSLV is a power of two so that every slave index decodes. The bench models the slaves as registered memories with exactly that one-cycle latency. It drives requests only between clock edges and leaves one idle cycle after each request, so a response never overlaps a new decode. Expected results come from the bench's own copy of the attribute settings, checked over every combination of slave, master and world flag.

// File: rtl/sec_filt_pkg.sv
package sec_filt_pkg;
  typedef enum logic [2:0] {
    CFG_SLV_ATTR = 3'd0,
    CFG_MST_ATTR = 3'd1,
    CFG_WIN_BASE = 3'd2,
    CFG_WIN_LIM  = 3'd3,
    CFG_CTRL     = 3'd4,
    CFG_VSTAT    = 3'd5,
    CFG_VADDR    = 3'd6,
    CFG_VINFO    = 3'd7
  } cfg_reg_e;

  localparam int CTRL_LOCK_BIT = 0;
  localparam int CTRL_WIN_BIT  = 1;
endpackage

// File: rtl/sec_addr_decode.sv
module sec_addr_decode #(
  parameter int AW      = 16,
  parameter int NSLV    = 4,
  parameter int WIN_SLV = 0,
  localparam int SB     = $clog2(NSLV)
) (
  input  logic [AW-1:0]   addr,
  input  logic [NSLV-1:0] slv_sec,
  input  logic [AW-1:0]   win_base,
  input  logic [AW-1:0]   win_limit,
  input  logic            win_en,
  output logic            is_cfg,
  output logic [SB-1:0]   idx,
  output logic            tgt_sec
);
  logic win_hit;

  always_comb begin
    is_cfg  = addr[AW-1];
    idx     = addr[AW-2 -: SB];
    win_hit = win_en && !is_cfg && (idx == SB'(WIN_SLV)) &&
              (addr >= win_base) && (addr <= win_limit);
    // configuration space is always secure
    tgt_sec = is_cfg || slv_sec[idx] || win_hit;
  end
endmodule

// File: rtl/sec_cfg_regs.sv
module sec_cfg_regs
  import sec_filt_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int NSLV = 4,
  parameter int NMST = 4,
  parameter int MIDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      reg_idx,
  input  logic [DW-1:0]   wdata,
  input  logic            cap_vld,
  input  logic [AW-1:0]   cap_addr,
  input  logic [MIDW:0]   cap_info,
  output logic [NSLV-1:0] slv_sec,
  output logic [NMST-1:0] mst_sec,
  output logic [AW-1:0]   win_base,
  output logic [AW-1:0]   win_limit,
  output logic            win_en,
  output logic            locked,
  output logic            clr_viol,
  output logic [DW-1:0]   rdata
);
  cfg_reg_e        sel;
  logic [NSLV-1:0] slv_q, slv_d;
  logic [NMST-1:0] mst_q, mst_d;
  logic [AW-1:0]   base_q, base_d, lim_q, lim_d;
  logic            wen_q, wen_d, lock_q, lock_d;
  logic [DW-1:0]   rd_q, rd_d;
  logic            open_wr;

  always_comb begin
    sel     = cfg_reg_e'(reg_idx);
    open_wr = wr_en && !lock_q;
    slv_d   = slv_q;
    mst_d   = mst_q;
    base_d  = base_q;
    lim_d   = lim_q;
    wen_d   = wen_q;
    lock_d  = lock_q;
    if (open_wr) begin
      case (sel)
        CFG_SLV_ATTR: slv_d  = wdata[NSLV-1:0];
        CFG_MST_ATTR: mst_d  = wdata[NMST-1:0];
        CFG_WIN_BASE: base_d = wdata[AW-1:0];
        CFG_WIN_LIM:  lim_d  = wdata[AW-1:0];
        CFG_CTRL: begin
          wen_d  = wdata[CTRL_WIN_BIT];
          lock_d = wdata[CTRL_LOCK_BIT];
        end
        default: ;
      endcase
    end
    clr_viol = wr_en && (sel == CFG_VSTAT) && wdata[0];

    rd_d = '0;
    case (sel)
      CFG_SLV_ATTR: rd_d[NSLV-1:0] = slv_q;
      CFG_MST_ATTR: rd_d[NMST-1:0] = mst_q;
      CFG_WIN_BASE: rd_d[AW-1:0]   = base_q;
      CFG_WIN_LIM:  rd_d[AW-1:0]   = lim_q;
      CFG_CTRL: begin
        rd_d[CTRL_WIN_BIT]  = wen_q;
        rd_d[CTRL_LOCK_BIT] = lock_q;
      end
      CFG_VSTAT:    rd_d[0]        = cap_vld;
      CFG_VADDR:    rd_d[AW-1:0]   = cap_addr;
      CFG_VINFO:    rd_d[MIDW:0]   = cap_info;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slv_q  <= '1;
      mst_q  <= '0;
      base_q <= '0;
      lim_q  <= '0;
      wen_q  <= 1'b0;
      lock_q <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (open_wr) begin
        slv_q  <= slv_d;
        mst_q  <= mst_d;
        base_q <= base_d;
        lim_q  <= lim_d;
        wen_q  <= wen_d;
        lock_q <= lock_d;
      end
      if (rd_en) rd_q <= rd_d;
    end
  end

  assign slv_sec   = slv_q;
  assign mst_sec   = mst_q;
  assign win_base  = base_q;
  assign win_limit = lim_q;
  assign win_en    = wen_q;
  assign locked    = lock_q;
  assign rdata     = rd_q;

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_attr_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> ($stable(slv_q) && $stable(mst_q) && $stable(base_q) &&
                $stable(lim_q) && $stable(wen_q)));
endmodule

// File: rtl/sec_viol_log.sv
module sec_viol_log #(
  parameter int AW   = 16,
  parameter int MIDW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            blk,
  input  logic [AW-1:0]   addr,
  input  logic [MIDW-1:0] mid,
  input  logic            wr,
  input  logic            clr,
  output logic            pulse,
  output logic            vld,
  output logic [AW-1:0]   cap_addr,
  output logic [MIDW:0]   cap_info
);
  logic          vld_q, vld_d, cap_en, pulse_q;
  logic [AW-1:0] addr_q;
  logic [MIDW:0] info_q;

  always_comb begin
    vld_d  = vld_q;
    cap_en = 1'b0;
    if (clr) begin
      vld_d = 1'b0;
    end else if (blk && !vld_q) begin
      vld_d  = 1'b1;
      cap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      pulse_q <= 1'b0;
      addr_q  <= '0;
      info_q  <= '0;
    end else begin
      vld_q   <= vld_d;
      pulse_q <= blk;
      if (cap_en) begin
        addr_q <= addr;
        info_q <= {wr, mid};
      end
    end
  end

  assign pulse    = pulse_q;
  assign vld      = vld_q;
  assign cap_addr = addr_q;
  assign cap_info = info_q;

  p_first_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !clr) |=> ($stable(addr_q) && $stable(info_q) && vld_q));
  p_pulse_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    blk |=> pulse_q);
endmodule

// File: rtl/sec_bus_filter.sv
module sec_bus_filter
  import sec_filt_pkg::*;
#(
  parameter int AW     = 16,
  parameter int DW     = 32,
  parameter int NSLV   = 4,
  parameter int NMST   = 4,
  parameter int CPU_ID = 0,
  localparam int SB    = $clog2(NSLV),
  localparam int MIDW  = $clog2(NMST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic              req_ns,
  input  logic [MIDW-1:0]   req_mid,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DW-1:0]     rsp_rdata,
  output logic [NSLV-1:0]   slv_sel,
  output logic              slv_write,
  output logic [AW-1:0]     slv_addr,
  output logic [DW-1:0]     slv_wdata,
  input  logic [NSLV*DW-1:0] slv_rdata,
  output logic              viol_pulse
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ni = rst_sync[1];

  logic [NSLV-1:0] slv_sec;
  logic [NMST-1:0] mst_sec;
  logic [AW-1:0]   win_base, win_limit, cap_addr;
  logic [MIDW:0]   cap_info;
  logic            win_en, locked, clr_viol, cap_vld;
  logic            is_cfg, tgt_sec, eff_ns, allowed, blocked;
  logic            cfg_wr, cfg_rd;
  logic [SB-1:0]   idx;
  logic [DW-1:0]   cfg_rdata;

  sec_addr_decode #(.AW(AW), .NSLV(NSLV), .WIN_SLV(0)) u_dec (
    .addr(req_addr), .slv_sec(slv_sec), .win_base(win_base),
    .win_limit(win_limit), .win_en(win_en),
    .is_cfg(is_cfg), .idx(idx), .tgt_sec(tgt_sec));

  always_comb begin
    if (req_mid == MIDW'(CPU_ID)) eff_ns = req_ns;
    else                          eff_ns = !mst_sec[req_mid];
    allowed = !eff_ns || !tgt_sec;
    blocked = req_valid && !allowed;
    cfg_wr  = req_valid && allowed && is_cfg && req_write;
    cfg_rd  = req_valid && allowed && is_cfg && !req_write;
  end

  for (genvar i = 0; i < NSLV; i++) begin : g_sel
    assign slv_sel[i] = req_valid && allowed && !is_cfg && (idx == SB'(i));
  end
  assign slv_write = req_write;
  assign slv_addr  = req_addr;
  assign slv_wdata = req_wdata;

  sec_cfg_regs #(.AW(AW), .DW(DW), .NSLV(NSLV), .NMST(NMST), .MIDW(MIDW)) u_cfg (
    .clk(clk), .rst_n(rst_ni), .wr_en(cfg_wr), .rd_en(cfg_rd),
    .reg_idx(req_addr[4:2]), .wdata(req_wdata),
    .cap_vld(cap_vld), .cap_addr(cap_addr), .cap_info(cap_info),
    .slv_sec(slv_sec), .mst_sec(mst_sec), .win_base(win_base),
    .win_limit(win_limit), .win_en(win_en), .locked(locked),
    .clr_viol(clr_viol), .rdata(cfg_rdata));

  sec_viol_log #(.AW(AW), .MIDW(MIDW)) u_log (
    .clk(clk), .rst_n(rst_ni), .blk(blocked), .addr(req_addr),
    .mid(req_mid), .wr(req_write), .clr(clr_viol),
    .pulse(viol_pulse), .vld(cap_vld), .cap_addr(cap_addr),
    .cap_info(cap_info));

  // response stage
  logic          vld_q, err_q, rds_q, rdc_q;
  logic          vld_d, err_d, rds_d, rdc_d;
  logic [SB-1:0] idx_q;

  always_comb begin
    vld_d = req_valid;
    err_d = blocked;
    rds_d = req_valid && allowed && !is_cfg && !req_write;
    rdc_d = cfg_rd;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      rds_q <= 1'b0;
      rdc_q <= 1'b0;
      idx_q <= '0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
      rds_q <= rds_d;
      rdc_q <= rdc_d;
      if (req_valid) idx_q <= idx;
    end
  end

  always_comb begin
    if (rdc_q)      rsp_rdata = cfg_rdata;
    else if (rds_q) rsp_rdata = slv_rdata[idx_q*DW +: DW];
    else            rsp_rdata = '0;
  end
  assign rsp_valid = vld_q;
  assign rsp_err   = err_q;

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0(slv_sel));
  p_rsp_next_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid |=> rsp_valid);
  p_err_no_sel_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    req_valid && (slv_sel == '0) && !is_cfg |=> rsp_err);
  p_err_zero_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_err |-> (rsp_rdata == '0) && viol_pulse);
endmodule

// File: tb/sec_bus_filter_test.sv
module sec_bus_filter_test;
  localparam int AW = 16, DW = 32, NSLV = 4, NMST = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ns = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [1:0] req_mid = '0;
  logic rsp_valid, rsp_err, viol_pulse, slv_write;
  logic [DW-1:0] rsp_rdata, slv_wdata;
  logic [NSLV-1:0] slv_sel;
  logic [AW-1:0] slv_addr;
  logic [NSLV*DW-1:0] slv_rdata;

  int checks = 0, errors = 0;
  logic [DW-1:0] mem [NSLV][16];
  logic [DW-1:0] rdq [NSLV];

  always #5 clk = ~clk;

  sec_bus_filter uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ns(req_ns),
    .req_mid(req_mid), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .slv_sel(slv_sel), .slv_write(slv_write),
    .slv_addr(slv_addr), .slv_wdata(slv_wdata), .slv_rdata(slv_rdata),
    .viol_pulse(viol_pulse));

  // slave models: registered memories, one-cycle read latency
  always @(posedge clk) begin
    for (int s = 0; s < NSLV; s++) begin
      if (slv_sel[s]) begin
        if (slv_write) mem[s][slv_addr[5:2]] <= slv_wdata;
        else           rdq[s] <= mem[s][slv_addr[5:2]];
      end
    end
  end
  always_comb
    for (int s = 0; s < NSLV; s++) slv_rdata[s*DW +: DW] = rdq[s];

  function automatic logic [AW-1:0] sa(int s, int w);
    return AW'((s << 13) | (w << 2));
  endfunction
  function automatic logic [AW-1:0] ca(int r);
    return AW'(16'h8000 | (r << 2));
  endfunction

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  logic e, p;
  logic [DW-1:0] rd;

  task automatic xact(logic w, logic [AW-1:0] a, logic [DW-1:0] d, logic ns,
                      logic [1:0] mid);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    req_ns = ns; req_mid = mid;
    @(negedge clk);
    req_valid = 1'b0;
    e = rsp_err; rd = rsp_rdata; p = viol_pulse;
    if (rsp_valid !== 1'b1) chk("R1 rsp_valid", {31'b0, rsp_valid}, 1);
    @(negedge clk);
  endtask

  logic [NSLV-1:0] slv_m;
  logic [NMST-1:0] mst_m;

  task automatic sweep(int pass);
    for (int s = 0; s < NSLV; s++)
      for (int m = 0; m < NMST; m++)
        for (int ns = 0; ns < 2; ns++) begin
          automatic int w = m * 2 + ns;
          automatic logic [DW-1:0] d = 32'hA000_0000 | (pass << 12) | (s << 8) | (m << 4) | ns;
          automatic logic en = (m == 0) ? logic'(ns) : !mst_m[m];
          automatic logic xe = en && slv_m[s];
          xact(1, sa(s, w), ~d, 0, 0);
          xact(1, sa(s, w), d, logic'(ns), 2'(m));
          chk("R4 R2 write err", {31'b0, e}, {31'b0, xe});
          chk("R8 write pulse", {31'b0, p}, {31'b0, xe});
          xact(0, sa(s, w), 0, logic'(ns), 2'(m));
          chk("R3 R2 read err", {31'b0, e}, {31'b0, xe});
          chk("R1 R2 read data", rd, xe ? 32'h0 : d);
          xact(0, sa(s, w), 0, 0, 0);
          chk("R10 readback", rd, xe ? ~d : d);
        end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 rsp_valid idle", {31'b0, rsp_valid}, 0);
    chk("R9 pulse idle", {31'b0, viol_pulse}, 0);
    xact(0, ca(0), 0, 0, 0); chk("R9 slave attr", rd, 32'hF);
    xact(0, ca(1), 0, 0, 0); chk("R9 master attr", rd, 0);
    xact(0, ca(4), 0, 0, 0); chk("R9 control", rd, 0);
    xact(0, ca(5), 0, 0, 0); chk("R9 viol valid", rd, 0);

    slv_m = 4'hF; mst_m = 4'h0;
    sweep(0);

    xact(1, ca(0), 32'h5, 0, 0);
    xact(1, ca(1), 32'h4, 0, 0);
    slv_m = 4'h5; mst_m = 4'h4;
    sweep(1);

    // window over slave 0 words 4..7
    xact(1, ca(0), 32'h4, 0, 0);
    xact(1, ca(2), {16'h0, sa(0, 4)}, 0, 0);
    xact(1, ca(3), {16'h0, sa(0, 7)}, 0, 0);
    xact(1, ca(4), 32'h2, 0, 0);
    for (int w = 0; w < 16; w++) begin
      xact(0, sa(0, w), 0, 1, 0);
      chk("R5 window normal", {31'b0, e}, {31'b0, logic'(w >= 4 && w <= 7)});
      xact(0, sa(0, w), 0, 0, 2);
      chk("R5 R4 window secure dma", {31'b0, e}, 0);
    end

    // violation capture
    xact(1, ca(5), 32'h1, 0, 0);
    xact(0, ca(5), 0, 0, 0); chk("R8 cleared", rd, 0);
    xact(0, sa(0, 5), 0, 1, 1);
    chk("R8 first pulse", {31'b0, p}, 1);
    xact(1, sa(2, 1), 32'h77, 0, 3);
    chk("R8 second pulse", {31'b0, p}, 1);
    xact(0, ca(5), 0, 0, 0); chk("R8 valid", rd, 1);
    xact(0, ca(6), 0, 0, 0); chk("R8 addr", rd, {16'h0, sa(0, 5)});
    xact(0, ca(7), 0, 0, 0); chk("R8 info", rd, 32'h1);
    xact(1, ca(5), 32'h1, 0, 0);
    xact(0, ca(5), 0, 0, 0); chk("R8 clear", rd, 0);

    // config space secure only
    xact(1, ca(0), 32'h0, 1, 0);
    chk("R7 normal cpu cfg err", {31'b0, e}, 1);
    xact(1, ca(1), 32'hF, 0, 1);
    chk("R7 normal dma cfg err", {31'b0, e}, 1);
    xact(0, ca(0), 0, 0, 0); chk("R7 slv attr kept", rd, 32'h4);
    xact(0, ca(1), 0, 0, 0); chk("R7 mst attr kept", rd, 32'h4);

    // lock
    xact(1, ca(4), 32'h3, 0, 0);
    xact(0, ca(4), 0, 0, 0); chk("R6 locked", rd, 32'h3);
    xact(1, ca(0), 32'hF, 0, 0); chk("R6 write no err", {31'b0, e}, 0);
    xact(1, ca(1), 32'hF, 0, 0);
    xact(1, ca(3), 32'h0, 0, 0);
    xact(1, ca(4), 32'h0, 0, 0);
    xact(0, ca(0), 0, 0, 0); chk("R6 slv frozen", rd, 32'h4);
    xact(0, ca(1), 0, 0, 0); chk("R6 mst frozen", rd, 32'h4);
    xact(0, ca(3), 0, 0, 0); chk("R6 limit frozen", rd, {16'h0, sa(0, 7)});
    xact(0, ca(4), 0, 0, 0); chk("R6 lock sticky", rd, 32'h3);
    xact(0, sa(0, 6), 0, 1, 0); chk("R6 window still on", {31'b0, e}, 1);
    xact(0, sa(1, 0), 0, 0, 3); chk("R6 dma3 normal on normal slave", {31'b0, e}, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule